// File: doc/BRIEF.md
# Power-Down Clock Wake Controller

This block gates the internal clock of a small serial-register peripheral. A software power-down bit starts a drain delay; when the delay runs out the clock enable drops. While the clock is off, selected edges on the serial clock line and on three line-status signals turn it back on. After a wake the clock stays on for a keep-alive window. If the power-down bit is still set when that window ends, the clock stops again. If the bit has been cleared, the clock stays on.

The block runs from an always-on clock and owns the clock-enable decision. It raises a clock-ready flag once the restarted clock has had time to settle. It raises a sticky interrupt after a wake that came from a status event, but not after a wake caused by the serial clock line going low. It also reports whether a serial register access can be served now. In the four-wire serial mode an access is always served. In the two-wire mode it needs a ready clock. All asynchronous inputs pass through a synchronizer, so each transition counts as a single event.

Top module: `pd_clk_wake`

## Requirements
- R1: After reset, clk_en, clk_ready and acc_ok are 1 and irq is 0.
- R2: With pd_req set and no wake, clk_en and clk_ready fall exactly PD_DLY+3 clock edges after pd_req rises (two synchronizer stages, one decision edge, then PD_DLY cycles of drain).
- R3: If pd_req clears before the drain delay completes, the clock enable never falls.
- R4: While the clock is off, a high-to-low transition of sclk_in wakes the clock only when twowire_sel is 1, and such a wake never raises irq.
- R5: While the clock is off, a rising sess_vld wakes the clock only if en_sess_hi is 1.
- R6: While the clock is off, a falling id_float wakes the clock only if en_id_lo is 1, and a rising id_float wakes it only if en_id_hi is 1. Each enable qualifies only its own edge direction.
- R7: While the clock is off, a rising se1_line wakes the clock only if en_se1_hi is 1.
- R8: A wake sets clk_en exactly 3 edges after the input transition. If pd_req stays set, clk_en then stays high for exactly WIN_LEN cycles.
- R9: clk_ready rises exactly SETTLE edges after clk_en rises on a wake. It is never high while clk_en is low.
- R10: After a wake with at least one qualified status event, irq rises one edge after clk_ready. It stays high until an irq_clr pulse clears it on the next edge.
- R11: With twowire_sel at 1, acc_ok follows clk_ready. With twowire_sel at 0, acc_ok stays 1 even while the clock is off.
- R12: A qualified event during a keep-alive window restarts the window, so clk_en then stays high for WIN_LEN cycles counted from that event's decision edge.
- R13: Clearing pd_req during a keep-alive window keeps the clock on indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_req | input | 1 | Software power-down bit |
| twowire_sel | input | 1 | 1 selects two-wire serial mode, 0 selects four-wire mode |
| sclk_in | input | 1 | Serial clock line, idle high |
| sess_vld | input | 1 | Session-valid status |
| id_float | input | 1 | ID-float status |
| se1_line | input | 1 | Single-ended-one line status |
| en_sess_hi | input | 1 | Enable for a rising session-valid event |
| en_id_lo | input | 1 | Enable for a falling ID-float event |
| en_id_hi | input | 1 | Enable for a rising ID-float event |
| en_se1_hi | input | 1 | Enable for a rising single-ended-one event |
| irq_clr | input | 1 | One-cycle interrupt clear strobe |
| clk_en | output | 1 | Internal clock enable |
| clk_ready | output | 1 | Clock running and settled |
| irq | output | 1 | Sticky wake interrupt |
| acc_ok | output | 1 | A serial register access can be served now |

## Verification
The assertions assume that every asynchronous input holds each level for longer than the synchronizer depth plus one cycle. They also assume that irq_clr and the four enables are driven in the always-on clock domain. The stimulus changes inputs only at the falling clock edge and holds each level for several cycles. It sets the enables before the edge they qualify and pulses irq_clr for exactly one cycle. Baseline levels of the status inputs are set while the clock is still running and the enables are low, so the first qualified edge is the one under test.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_DRAIN = 2'd1,
    PS_OFF   = 2'd2,
    PS_WIN   = 2'd3
  } pwr_state_t;

  // positions inside the synchronized input vector
  localparam int SI_PD   = 0;
  localparam int SI_TW   = 1;
  localparam int SI_SCLK = 2;
  localparam int SI_SESS = 3;
  localparam int SI_ID   = 4;
  localparam int SI_SE1  = 5;
  localparam int SI_NUM  = 6;

  // positions inside the event vector (sclk first: it is the only cause without irq)
  localparam int EV_SCLK = 0;
  localparam int EV_NUM  = 4;
endpackage

// File: rtl/pdw_sync.sv
module pdw_sync #(
  parameter int          W       = 6,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= RST_VAL;
          else     stg[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= RST_VAL;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q_out = stg[STAGES-1];
endmodule

// File: rtl/pdw_edge.sv
module pdw_edge #(
  parameter int           W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  // R6: a single transition produces a single-cycle event
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    (|rise) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/pdw_wake_qual.sv
module pdw_wake_qual
  import pdw_pkg::*;
#(
  parameter int N = EV_NUM
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] rise,
  input  logic [N-1:0] fall,
  input  logic [N-1:0] rise_en,
  input  logic [N-1:0] fall_en,
  output logic         wake_any,
  output logic         wake_irq
);
  logic [N-1:0] hit;

  assign hit      = (rise & rise_en) | (fall & fall_en);
  assign wake_any = |hit;
  assign wake_irq = |(hit & ~(N'(1) << EV_SCLK));

  // R4: an interrupt-worthy cause is always also a wake cause
  p_irq_cause_is_wake_r4: assert property (@(posedge clk) disable iff (rst)
    wake_irq |-> wake_any);
endmodule

// File: rtl/pdw_seq.sv
module pdw_seq
  import pdw_pkg::*;
#(
  parameter int PD_DLY  = 16,
  parameter int WIN_LEN = 12,
  parameter int SETTLE  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_s,
  input  logic tw_s,
  input  logic wake_any,
  input  logic wake_irq,
  input  logic irq_clr,
  output logic clk_en,
  output logic clk_ready,
  output logic irq,
  output logic acc_ok
);
  localparam int CMAX = (PD_DLY > WIN_LEN) ? PD_DLY : WIN_LEN;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int SW   = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] PD_LAST  = CW'(PD_DLY - 1);
  localparam logic [CW-1:0] WIN_LAST = CW'(WIN_LEN - 1);
  localparam logic [SW-1:0] SET_MAX  = SW'(SETTLE);

  pwr_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] set_q, set_d;
  logic          clk_en_q, ready_q, irq_q, acc_q, pend_q;
  logic          ready_d, pend_set, irq_fire;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PS_RUN: begin
        if (pd_s) begin
          state_d = PS_DRAIN;
          cnt_d   = '0;
        end
      end
      PS_DRAIN: begin
        if (!pd_s)                 state_d = PS_RUN;
        else if (cnt_q == PD_LAST) state_d = PS_OFF;
        else                       cnt_d   = cnt_q + 1'b1;
      end
      PS_OFF: begin
        if (wake_any) begin
          state_d = PS_WIN;
          cnt_d   = '0;
        end
      end
      PS_WIN: begin
        if (!pd_s)                  state_d = PS_RUN;
        else if (wake_any)          cnt_d   = '0;
        else if (cnt_q == WIN_LAST) state_d = PS_OFF;
        else                        cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = PS_RUN;
    endcase
  end

  always_comb begin
    if (state_q == PS_OFF)    set_d = '0;
    else if (set_q == SET_MAX) set_d = set_q;
    else                       set_d = set_q + 1'b1;
  end

  assign ready_d  = (state_d != PS_OFF) && (set_d == SET_MAX);
  assign pend_set = wake_irq && (state_q == PS_OFF || state_q == PS_WIN);
  assign irq_fire = pend_q && ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PS_RUN;
      cnt_q    <= '0;
      set_q    <= SET_MAX;
      clk_en_q <= 1'b1;
      ready_q  <= 1'b1;
      acc_q    <= 1'b1;
      pend_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      set_q    <= set_d;
      clk_en_q <= (state_d != PS_OFF);
      ready_q  <= ready_d;
      acc_q    <= ~tw_s | ready_d;
      pend_q   <= pend_set | (pend_q & ~irq_fire);
      irq_q    <= irq_fire | (irq_q & ~irq_clr);
    end
  end

  assign clk_en    = clk_en_q;
  assign clk_ready = ready_q;
  assign irq       = irq_q;
  assign acc_ok    = acc_q;

  // R9: ready implies the clock is enabled
  p_ready_needs_clk_r9: assert property (@(posedge clk) disable iff (rst)
    clk_ready |-> clk_en);

  // R2: the clock only stops while power-down is requested
  p_stop_needs_pd_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_en) |-> $past(pd_s));

  // R10: the interrupt holds until a clear strobe
  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);

  // R11: an access is refused only when the clock is not ready
  p_refuse_only_unready_r11: assert property (@(posedge clk) disable iff (rst)
    !acc_ok |-> !clk_ready);

  // R8: the keep-alive counter stays inside its window
  p_win_range_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_WIN) |-> (cnt_q <= WIN_LAST));

  // R4: a qualified event while off enables the clock on the next edge
  p_wake_from_off_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_OFF && wake_any) |=> clk_en);
endmodule

// File: rtl/pd_clk_wake.sv
module pd_clk_wake
  import pdw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PD_DLY      = 16,
  parameter int WIN_LEN     = 12,
  parameter int SETTLE      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_req,
  input  logic twowire_sel,
  input  logic sclk_in,
  input  logic sess_vld,
  input  logic id_float,
  input  logic se1_line,
  input  logic en_sess_hi,
  input  logic en_id_lo,
  input  logic en_id_hi,
  input  logic en_se1_hi,
  input  logic irq_clr,
  output logic clk_en,
  output logic clk_ready,
  output logic irq,
  output logic acc_ok
);
  localparam logic [SI_NUM-1:0] SYNC_RST = SI_NUM'(1) << SI_SCLK;

  logic [SI_NUM-1:0] raw, syn;
  logic [EV_NUM-1:0] ev_lvl, ev_rise, ev_fall, rise_en, fall_en;
  logic              wake_any, wake_irq;

  assign raw = {se1_line, id_float, sess_vld, sclk_in, twowire_sel, pd_req};

  pdw_sync #(.W(SI_NUM), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d_in(raw), .q_out(syn)
  );

  assign ev_lvl = syn[SI_SE1:SI_SCLK];

  pdw_edge #(.W(EV_NUM), .RST_VAL(EV_NUM'(1))) u_edge (
    .clk(clk), .rst(rst), .lvl(ev_lvl), .rise(ev_rise), .fall(ev_fall)
  );

  // event order: {se1, id, sess, sclk}
  assign rise_en = {en_se1_hi, en_id_hi, en_sess_hi, 1'b0};
  assign fall_en = {1'b0, en_id_lo, 1'b0, syn[SI_TW]};

  pdw_wake_qual #(.N(EV_NUM)) u_qual (
    .clk(clk), .rst(rst),
    .rise(ev_rise), .fall(ev_fall), .rise_en(rise_en), .fall_en(fall_en),
    .wake_any(wake_any), .wake_irq(wake_irq)
  );

  pdw_seq #(.PD_DLY(PD_DLY), .WIN_LEN(WIN_LEN), .SETTLE(SETTLE)) u_seq (
    .clk(clk), .rst(rst),
    .pd_s(syn[SI_PD]), .tw_s(syn[SI_TW]),
    .wake_any(wake_any), .wake_irq(wake_irq), .irq_clr(irq_clr),
    .clk_en(clk_en), .clk_ready(clk_ready), .irq(irq), .acc_ok(acc_ok)
  );
endmodule

// File: tb/pd_clk_wake_test.sv
module pd_clk_wake_test;
  localparam int PD_DLY  = 16;
  localparam int WIN_LEN = 12;
  localparam int SETTLE  = 4;

  // {sel[2:0], en{se1,id_hi,id_lo,sess}[3:0], twowire, exp_wake, exp_irq}
  // sel: 0 sclk fall, 1 sess rise, 2 id fall, 3 id rise, 4 se1 rise
  localparam logic [9:0] VEC [10] = '{
    10'b000_0000_1_1_0,
    10'b000_0000_0_0_0,
    10'b001_0001_0_1_1,
    10'b001_1110_0_0_0,
    10'b010_0010_0_1_1,
    10'b010_0100_0_0_0,
    10'b011_0100_0_1_1,
    10'b011_0010_0_0_0,
    10'b100_1000_0_1_1,
    10'b100_0111_0_0_0
  };

  logic clk = 0, rst = 1;
  logic pd_req = 0, twowire_sel = 0, sclk_in = 1, sess_vld = 0, id_float = 0, se1_line = 0;
  logic en_sess_hi = 0, en_id_lo = 0, en_id_hi = 0, en_se1_hi = 0, irq_clr = 0;
  logic clk_en, clk_ready, irq, acc_ok;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  pd_clk_wake #(.PD_DLY(PD_DLY), .WIN_LEN(WIN_LEN), .SETTLE(SETTLE)) uut (
    .clk(clk), .rst(rst), .pd_req(pd_req), .twowire_sel(twowire_sel),
    .sclk_in(sclk_in), .sess_vld(sess_vld), .id_float(id_float), .se1_line(se1_line),
    .en_sess_hi(en_sess_hi), .en_id_lo(en_id_lo), .en_id_hi(en_id_hi),
    .en_se1_hi(en_se1_hi), .irq_clr(irq_clr),
    .clk_en(clk_en), .clk_ready(clk_ready), .irq(irq), .acc_ok(acc_ok)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1;
    tick(3);
    rst = 0;
    tick(4);
  endtask

  task automatic go_sleep();
    pd_req = 1;
    tick(PD_DLY + 3);
    check("R2", "clk_en after drain", clk_en, 0);
  endtask

  task automatic base_inputs(input logic tw, input logic id_hi);
    {en_se1_hi, en_id_hi, en_id_lo, en_sess_hi} = 4'b0000;
    pd_req = 0; irq_clr = 0; sclk_in = 1; sess_vld = 0; se1_line = 0;
    id_float = id_hi; twowire_sel = tw;
  endtask

  task automatic count_high(output int n);
    n = 0;
    while (clk_en && n < 200) begin
      n++;
      tick(1);
    end
  endtask

  function automatic string req_of(input logic [2:0] s);
    case (s)
      3'd0:    return "R4";
      3'd1:    return "R5";
      3'd4:    return "R7";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [2:0] sel;
    logic [3:0] en;
    logic tw, ew, ei;

    // R1: reset state
    base_inputs(1'b0, 1'b0);
    do_reset();
    check("R1", "clk_en", clk_en, 1);
    check("R1", "clk_ready", clk_ready, 1);
    check("R1", "irq", irq, 0);
    check("R1", "acc_ok", acc_ok, 1);

    // table of wake qualification cases
    for (int k = 0; k < 10; k++) begin
      {sel, en, tw, ew, ei} = VEC[k];
      base_inputs(tw, sel == 3'd2);
      do_reset();
      go_sleep();
      {en_se1_hi, en_id_hi, en_id_lo, en_sess_hi} = en;
      tick(2);
      case (sel)
        3'd0:    sclk_in  = 0;
        3'd1:    sess_vld = 1;
        3'd2:    id_float = 0;
        3'd3:    id_float = 1;
        default: se1_line = 1;
      endcase
      tick(3);
      check(req_of(sel), $sformatf("vector %0d wake", k), clk_en, ew);
      tick(SETTLE + 1);
      check(req_of(sel), $sformatf("vector %0d irq", k), irq, ei);
    end

    // R2: exact drain timing
    base_inputs(1'b0, 1'b0);
    do_reset();
    pd_req = 1;
    tick(PD_DLY + 2);
    check("R2", "clk_en one edge before stop", clk_en, 1);
    tick(1);
    check("R2", "clk_en at stop", clk_en, 0);
    check("R2", "clk_ready at stop", clk_ready, 0);

    // R3: cleared before drain completes
    base_inputs(1'b0, 1'b0);
    do_reset();
    pd_req = 1;
    tick(5);
    pd_req = 0;
    tick(PD_DLY + 10);
    check("R3", "clk_en stays on", clk_en, 1);

    // R9, R10, R11: settle, interrupt and access timing in two-wire mode
    base_inputs(1'b1, 1'b0);
    do_reset();
    go_sleep();
    check("R11", "acc_ok while off in two-wire", acc_ok, 0);
    en_sess_hi = 1;
    tick(2);
    sess_vld = 1;
    tick(3);
    check("R8", "clk_en 3 edges after event", clk_en, 1);
    check("R9", "clk_ready just after wake", clk_ready, 0);
    tick(SETTLE - 1);
    check("R9", "clk_ready one edge early", clk_ready, 0);
    tick(1);
    check("R9", "clk_ready after settle", clk_ready, 1);
    check("R11", "acc_ok with ready clock", acc_ok, 1);
    check("R10", "irq not yet", irq, 0);
    tick(1);
    check("R10", "irq after ready", irq, 1);
    tick(3);
    check("R10", "irq held", irq, 1);
    irq_clr = 1;
    tick(1);
    irq_clr = 0;
    check("R10", "irq cleared", irq, 0);

    // R11: four-wire mode serves access while off
    base_inputs(1'b0, 1'b0);
    do_reset();
    go_sleep();
    check("R11", "acc_ok while off in four-wire", acc_ok, 1);

    // R8: window length
    base_inputs(1'b0, 1'b0);
    do_reset();
    go_sleep();
    en_se1_hi = 1;
    tick(2);
    se1_line = 1;
    tick(3);
    count_high(n);
    check("R8", "window length", n, WIN_LEN);
    check("R9", "clk_ready drops with clk_en", clk_ready, 0);

    // R12: event during window restarts it
    base_inputs(1'b0, 1'b0);
    do_reset();
    go_sleep();
    en_se1_hi = 1;
    en_sess_hi = 1;
    tick(2);
    se1_line = 1;
    tick(3);
    tick(5);
    sess_vld = 1;
    tick(3);
    check("R12", "clk_en at restart", clk_en, 1);
    count_high(n);
    check("R12", "restarted window length", n, WIN_LEN);

    // R13: clearing power-down inside the window
    base_inputs(1'b0, 1'b0);
    do_reset();
    go_sleep();
    en_se1_hi = 1;
    tick(2);
    se1_line = 1;
    tick(4);
    pd_req = 0;
    tick(WIN_LEN * 3);
    check("R13", "clk_en stays on", clk_en, 1);
    check("R13", "clk_ready stays on", clk_ready, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule